// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block sequences the clocks and the CPU of a small 8-bit microcontroller through four power modes. It drives the enable of a fast main oscillator and of a slow sub-oscillator. It also chooses which of the two clocks the CPU runs on and whether the CPU runs or is halted. Two control bits and a sleep strobe from the core pick the mode: a CPU clock source bit and an idle enable bit. Wake-up events, such as a watchdog or timer expiry, and external interrupts bring the part back out of a halted mode.

Whenever the main oscillator has to restart, the block holds the CPU halted for a fixed number of warm-up cycles before it selects the fast clock. The same control word also carries two bits that the block passes on to its neighbours. One picks the clock for the timer/counter blocks. The other picks a short or long watchdog time-out, which the block turns into a sub-oscillator tick count.

The mode code on `mode` is 0 for normal, 1 for green (slow), 2 for idle and 3 for sleep. During a main-oscillator warm-up the code reads 0 and `cpu_run` is low.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, `mode`=0, both oscillator enables are 1, `cpu_clk_main`=1, `cpu_run`=1, `tmr_clk_main`=0 and `wdt_limit` holds the short count. The control bits reset to: clock source bit 1, idle bit 0, timer bit 0, watchdog bit 0.
- R2: In normal mode, once the clock source bit has been written to 0, the block enters green mode (`mode`=1). In green mode `main_osc_en`=0, `sub_osc_en`=1, `cpu_clk_main`=0 and `cpu_run`=1. This takes effect two clock edges after the write.
- R3: In green mode, writing the clock source bit to 1 starts a warm-up. During the warm-up `main_osc_en`=1, `sub_osc_en`=1, `cpu_clk_main`=0, `cpu_run`=0 and `mode`=0. It lasts exactly WARMUP_CYCLES cycles, after which `cpu_clk_main`=1 and `cpu_run`=1.
- R4: If `sleep_req` arrives in normal or green mode while the idle bit is 1, the block enters idle mode (`mode`=2) on the next edge. In idle mode `main_osc_en`=0, `sub_osc_en`=1 and `cpu_run`=0.
- R5: If `sleep_req` arrives in normal or green mode while the idle bit is 0, the block enters sleep mode (`mode`=3) on the next edge, with both oscillator enables at 0 and `cpu_run`=0.
- R6: Sleep mode is left only on `wake_evt` or `ext_irq`. The block then always goes through the warm-up into normal mode, and the clock source bit is forced to 1.
- R7: Idle mode is left on `wake_evt` or `ext_irq`. If idle was entered from green mode, the block returns to green on the next edge. If it was entered from normal mode, it returns through the warm-up to normal.
- R8: `sleep_req` has no effect in idle mode, in sleep mode or during a warm-up.
- R9: Writes to the control bits are ignored outside normal and green mode.
- R10: `tmr_clk_main` equals the timer clock bit: 1 selects the main oscillator and 0 the sub-oscillator. It is updated one edge after the write.
- R11: `wdt_limit` is SUB_KHZ*9/2 sub-oscillator ticks (4.5 ms) when the watchdog bit is 0, and SUB_KHZ*18 ticks (18 ms) when it is 1.
- R12: In normal or green mode, `sleep_req` takes priority over a clock source change that is pending in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Write strobe for the four control bits |
| cfg_cpu_main | input | 1 | Clock source bit: 1 main oscillator, 0 sub-oscillator |
| cfg_idle_en | input | 1 | Idle bit: 1 the sleep strobe gives idle, 0 it gives sleep |
| cfg_tmr_main | input | 1 | Timer clock bit: 1 main, 0 sub |
| cfg_wdt_long | input | 1 | Watchdog bit: 1 long, 0 short time-out |
| sleep_req | input | 1 | One-cycle sleep-instruction strobe from the core |
| wake_evt | input | 1 | Wake-up event (watchdog, timer) |
| ext_irq | input | 1 | External interrupt |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_osc_en | output | 1 | Sub-oscillator enable |
| cpu_clk_main | output | 1 | CPU clock select: 1 main, 0 sub |
| cpu_run | output | 1 | 1 CPU clocked, 0 CPU halted |
| mode | output | 2 | Mode code: 0 normal, 1 green, 2 idle, 3 sleep |
| tmr_clk_main | output | 1 | Timer clock select for the timer/counter blocks |
| wdt_limit | output | $clog2(SUB_KHZ*18+1) | Watchdog time-out in sub-oscillator ticks |

## Verification
A strobe (`sleep_req`, `wake_evt`, `ext_irq`) changes the mode outputs one edge later. A control write reaches `tmr_clk_main` and `wdt_limit` one edge later and moves the mode two edges later. A warm-up adds exactly WARMUP_CYCLES edges on top. Each table row applies its stimulus for one cycle and then waits a number of extra edges set from these latencies. Outputs are sampled on the falling edge, so a check lands in the first cycle a result is due. Where a warm-up boundary matters, checks one cycle early confirm that the result has not yet appeared.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL = 3'd0,
    ST_GREEN  = 3'd1,
    ST_IDLE   = 3'd2,
    ST_SLEEP  = 3'd3,
    ST_WARM   = 3'd4
  } pmc_state_e;

  localparam logic [1:0] MODE_NORMAL = 2'd0;
  localparam logic [1:0] MODE_GREEN  = 2'd1;
  localparam logic [1:0] MODE_IDLE   = 2'd2;
  localparam logic [1:0] MODE_SLEEP  = 2'd3;

  typedef struct packed {
    logic cpu_main;
    logic idle_en;
    logic tmr_main;
    logic wdt_long;
  } pmc_cfg_t;

endpackage

// File: rtl/pmc_cfg_reg.sv
module pmc_cfg_reg
  import pmc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     we,
  input  pmc_cfg_t wr_data,
  input  logic     allow,
  input  logic     force_main,
  output pmc_cfg_t cfg_q
);

  pmc_cfg_t cfg_d;
  logic     cfg_en;

  always_comb begin
    cfg_en = force_main | (we & allow);
    cfg_d  = cfg_q;
    if (we && allow) cfg_d = wr_data;
    if (force_main)  cfg_d.cpu_main = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{cpu_main: 1'b1, idle_en: 1'b0, tmr_main: 1'b0, wdt_long: 1'b0};
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!allow && !force_main) |=> $stable(cfg_q)); // R9

  AST_WAKE_FORCES_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    force_main |=> cfg_q.cpu_main); // R6

endmodule

// File: rtl/pmc_warmup.sv
module pmc_warmup #(
  parameter int unsigned WARMUP_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic done
);

  localparam int unsigned CW = (WARMUP_CYCLES > 1) ? $clog2(WARMUP_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WARMUP_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (!active)      cnt_d = '0;
    else if (done)    cnt_d = cnt_q;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = active && (cnt_q == LAST);

  AST_WARM_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q <= LAST)); // R3

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       wake_any,
  input  logic       cpu_main,
  input  logic       idle_en,
  input  logic       warm_done,
  output logic       allow_cfg,
  output logic       force_main,
  output logic       warm_active,
  output logic       main_osc_en,
  output logic       sub_osc_en,
  output logic       cpu_clk_main,
  output logic       cpu_run,
  output logic [1:0] mode
);

  pmc_state_e st_q, st_d;
  logic       ret_green_q, ret_green_d, ret_en;

  assign allow_cfg   = (st_q == ST_NORMAL) || (st_q == ST_GREEN);
  assign ret_en      = allow_cfg && sleep_req;
  assign force_main  = (st_q == ST_SLEEP) && wake_any;
  assign warm_active = (st_q == ST_WARM);

  always_comb begin
    st_d        = st_q;
    ret_green_d = (st_q == ST_GREEN);
    case (st_q)
      ST_NORMAL: begin
        if (sleep_req)     st_d = idle_en ? ST_IDLE : ST_SLEEP;
        else if (!cpu_main) st_d = ST_GREEN;
      end
      ST_GREEN: begin
        if (sleep_req)     st_d = idle_en ? ST_IDLE : ST_SLEEP;
        else if (cpu_main) st_d = ST_WARM;
      end
      ST_IDLE:  if (wake_any) st_d = ret_green_q ? ST_GREEN : ST_WARM;
      ST_SLEEP: if (wake_any) st_d = ST_WARM;
      ST_WARM:  if (warm_done) st_d = ST_NORMAL;
      default:  st_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_NORMAL;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ret_green_q <= 1'b0;
    else if (ret_en) ret_green_q <= ret_green_d;
  end

  always_comb begin
    main_osc_en  = 1'b0;
    sub_osc_en   = 1'b1;
    cpu_clk_main = 1'b0;
    cpu_run      = 1'b0;
    mode         = MODE_NORMAL;
    case (st_q)
      ST_NORMAL: begin
        main_osc_en  = 1'b1;
        cpu_clk_main = 1'b1;
        cpu_run      = 1'b1;
      end
      ST_GREEN: begin
        cpu_run = 1'b1;
        mode    = MODE_GREEN;
      end
      ST_IDLE:  mode = MODE_IDLE;
      ST_SLEEP: begin
        sub_osc_en = 1'b0;
        mode       = MODE_SLEEP;
      end
      ST_WARM:  main_osc_en = 1'b1;
      default:  mode = MODE_NORMAL;
    endcase
  end

  AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (allow_cfg && sleep_req && idle_en) |=> (mode == MODE_IDLE)); // R4

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (allow_cfg && sleep_req && !idle_en) |=> (mode == MODE_SLEEP)); // R5

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_SLEEP) && !wake_any) |=> (mode == MODE_SLEEP)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) && !wake_any) |=> (mode == MODE_IDLE)); // R8

  AST_IDLE_BACK_GREEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) && wake_any && ret_green_q) |=> (mode == MODE_GREEN)); // R7

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned WARMUP_CYCLES = 8,
  parameter int unsigned SUB_KHZ       = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic                              cfg_cpu_main,
  input  logic                              cfg_idle_en,
  input  logic                              cfg_tmr_main,
  input  logic                              cfg_wdt_long,
  input  logic                              sleep_req,
  input  logic                              wake_evt,
  input  logic                              ext_irq,
  output logic                              main_osc_en,
  output logic                              sub_osc_en,
  output logic                              cpu_clk_main,
  output logic                              cpu_run,
  output logic [1:0]                        mode,
  output logic                              tmr_clk_main,
  output logic [$clog2(SUB_KHZ*18+1)-1:0]   wdt_limit
);

  localparam int unsigned WDT_W     = $clog2(SUB_KHZ * 18 + 1);
  localparam int unsigned WDT_SHORT = (SUB_KHZ * 9) / 2;
  localparam int unsigned WDT_LONG  = SUB_KHZ * 18;

  pmc_cfg_t cfg_q;
  pmc_cfg_t wr_data;
  logic     allow_cfg, force_main, warm_active, warm_done, wake_any;

  assign wr_data  = '{cpu_main: cfg_cpu_main, idle_en: cfg_idle_en,
                      tmr_main: cfg_tmr_main, wdt_long: cfg_wdt_long};
  assign wake_any = wake_evt | ext_irq;

  pmc_cfg_reg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (cfg_we),
    .wr_data    (wr_data),
    .allow      (allow_cfg),
    .force_main (force_main),
    .cfg_q      (cfg_q)
  );

  pmc_warmup #(.WARMUP_CYCLES(WARMUP_CYCLES)) u_warm (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (warm_active),
    .done   (warm_done)
  );

  pmc_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_req    (sleep_req),
    .wake_any     (wake_any),
    .cpu_main     (cfg_q.cpu_main),
    .idle_en      (cfg_q.idle_en),
    .warm_done    (warm_done),
    .allow_cfg    (allow_cfg),
    .force_main   (force_main),
    .warm_active  (warm_active),
    .main_osc_en  (main_osc_en),
    .sub_osc_en   (sub_osc_en),
    .cpu_clk_main (cpu_clk_main),
    .cpu_run      (cpu_run),
    .mode         (mode)
  );

  assign tmr_clk_main = cfg_q.tmr_main;
  assign wdt_limit    = cfg_q.wdt_long ? WDT_W'(WDT_LONG) : WDT_W'(WDT_SHORT);

  AST_CLK_NEEDS_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_main |-> main_osc_en); // R2

  AST_WARM_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_osc_en) |-> !cpu_run); // R3

  AST_RUN_ONLY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_run |-> (mode == MODE_NORMAL || mode == MODE_GREEN)); // R8

  AST_TMR_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && allow_cfg) |=> (tmr_clk_main == $past(cfg_tmr_main))); // R10

endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;

  localparam int WU  = 8;
  localparam int SUB = 32;
  localparam int WW  = $clog2(SUB * 18 + 1);

  typedef struct packed {
    logic       we;
    logic       cpu;
    logic       idle;
    logic       slp;
    logic       wake;
    logic       irq;
    logic [3:0] wt;
    logic [1:0] mode;
    logic       mo;
    logic       so;
    logic       ck;
    logic       run;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0, 4'd1,      2'd1, 1'b0,1'b1,1'b0,1'b1, 4'd2},  // R2 to green
    '{1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0, 4'd1,      2'd0, 1'b1,1'b1,1'b0,1'b0, 4'd3},  // R3 warm-up start
    '{1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 4'(WU-2),  2'd0, 1'b1,1'b1,1'b0,1'b0, 4'd3},  // R3 last warm cycle
    '{1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 4'd0,      2'd0, 1'b1,1'b1,1'b1,1'b1, 4'd3},  // R3 normal again
    '{1'b1,1'b1,1'b1, 1'b0,1'b0,1'b0, 4'd0,      2'd0, 1'b1,1'b1,1'b1,1'b1, 4'd9},  // idle bit set
    '{1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 4'd0,      2'd2, 1'b0,1'b1,1'b0,1'b0, 4'd4},  // R4 idle
    '{1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 4'd0,      2'd2, 1'b0,1'b1,1'b0,1'b0, 4'd8},  // R8 sleep in idle
    '{1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0, 4'd0,      2'd2, 1'b0,1'b1,1'b0,1'b0, 4'd9},  // R9 write in idle
    '{1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0, 4'd0,      2'd0, 1'b1,1'b1,1'b0,1'b0, 4'd7},  // R7 idle->warm
    '{1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 4'(WU-1),  2'd0, 1'b1,1'b1,1'b1,1'b1, 4'd7},  // R7 back to normal
    '{1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 4'd1,      2'd0, 1'b1,1'b1,1'b1,1'b1, 4'd9},  // R9 source bit kept
    '{1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 4'd0,      2'd2, 1'b0,1'b1,1'b0,1'b0, 4'd9},  // R9 idle bit kept
    '{1'b0,1'b0,1'b0, 1'b0,1'b0,1'b1, 4'(WU),    2'd0, 1'b1,1'b1,1'b1,1'b1, 4'd7},  // R7 irq exit
    '{1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0, 4'd0,      2'd0, 1'b1,1'b1,1'b1,1'b1, 4'd5},  // idle bit clear
    '{1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 4'd0,      2'd3, 1'b0,1'b0,1'b0,1'b0, 4'd5},  // R5 sleep
    '{1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 4'd5,      2'd3, 1'b0,1'b0,1'b0,1'b0, 4'd6},  // R6 R8 stays asleep
    '{1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0, 4'd0,      2'd0, 1'b1,1'b1,1'b0,1'b0, 4'd6},  // R6 warm-up
    '{1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 4'(WU-1),  2'd0, 1'b1,1'b1,1'b1,1'b1, 4'd6},  // R6 normal
    '{1'b1,1'b0,1'b1, 1'b0,1'b0,1'b0, 4'd1,      2'd1, 1'b0,1'b1,1'b0,1'b1, 4'd2},  // R2 green
    '{1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 4'd0,      2'd2, 1'b0,1'b1,1'b0,1'b0, 4'd4},  // R4 idle from green
    '{1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0, 4'd0,      2'd1, 1'b0,1'b1,1'b0,1'b1, 4'd7},  // R7 back to green
    '{1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0, 4'd0,      2'd1, 1'b0,1'b1,1'b0,1'b1, 4'd12}, // R12 change pending
    '{1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 4'd0,      2'd3, 1'b0,1'b0,1'b0,1'b0, 4'd12}, // R12 sleep wins
    '{1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0, 4'(WU),    2'd0, 1'b1,1'b1,1'b1,1'b1, 4'd6},  // R6 wake
    '{1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0, 4'd1,      2'd1, 1'b0,1'b1,1'b0,1'b1, 4'd2},  // R2 green
    '{1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 4'd0,      2'd3, 1'b0,1'b0,1'b0,1'b0, 4'd5},  // R5 sleep from green
    '{1'b0,1'b0,1'b0, 1'b0,1'b0,1'b1, 4'(WU),    2'd0, 1'b1,1'b1,1'b1,1'b1, 4'd6},  // R6 irq wake
    '{1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 4'd2,      2'd0, 1'b1,1'b1,1'b1,1'b1, 4'd6}   // R6 source forced
  };

  logic          clk, rst_n;
  logic          cfg_we, cfg_cpu_main, cfg_idle_en, cfg_tmr_main, cfg_wdt_long;
  logic          sleep_req, wake_evt, ext_irq;
  logic          main_osc_en, sub_osc_en, cpu_clk_main, cpu_run, tmr_clk_main;
  logic [1:0]    mode;
  logic [WW-1:0] wdt_limit;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  pwr_mode_ctrl #(.WARMUP_CYCLES(WU), .SUB_KHZ(SUB)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cpu_main(cfg_cpu_main),
    .cfg_idle_en(cfg_idle_en), .cfg_tmr_main(cfg_tmr_main), .cfg_wdt_long(cfg_wdt_long),
    .sleep_req(sleep_req), .wake_evt(wake_evt), .ext_irq(ext_irq),
    .main_osc_en(main_osc_en), .sub_osc_en(sub_osc_en), .cpu_clk_main(cpu_clk_main),
    .cpu_run(cpu_run), .mode(mode), .tmr_clk_main(tmr_clk_main), .wdt_limit(wdt_limit)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear_inputs();
    cfg_we = 1'b0; cfg_cpu_main = 1'b0; cfg_idle_en = 1'b0;
    cfg_tmr_main = 1'b0; cfg_wdt_long = 1'b0;
    sleep_req = 1'b0; wake_evt = 1'b0; ext_irq = 1'b0;
  endtask

  task automatic check_outs(input string tag, input vec_t v);
    check({tag, " mode"}, mode, v.mode);
    check({tag, " main_osc_en"}, main_osc_en, v.mo);
    check({tag, " sub_osc_en"}, sub_osc_en, v.so);
    check({tag, " cpu_clk_main"}, cpu_clk_main, v.ck);
    check({tag, " cpu_run"}, cpu_run, v.run);
  endtask

  initial begin
    clear_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 mode", mode, 0);
    check("R1 main_osc_en", main_osc_en, 1);
    check("R1 sub_osc_en", sub_osc_en, 1);
    check("R1 cpu_clk_main", cpu_clk_main, 1);
    check("R1 cpu_run", cpu_run, 1);
    check("R1 tmr_clk_main", tmr_clk_main, 0);
    check("R1 wdt_limit", int'(wdt_limit), SUB * 9 / 2);

    for (int i = 0; i < NV; i++) begin
      cfg_we       = VEC[i].we;
      cfg_cpu_main = VEC[i].cpu;
      cfg_idle_en  = VEC[i].idle;
      sleep_req    = VEC[i].slp;
      wake_evt     = VEC[i].wake;
      ext_irq      = VEC[i].irq;
      @(negedge clk);
      clear_inputs();
      for (int k = 0; k < int'(VEC[i].wt); k++) @(negedge clk);
      check_outs($sformatf("R%0d vec %0d", VEC[i].req, i), VEC[i]);
    end

    // R10 R11: timer and watchdog selects, now in normal mode
    cfg_we = 1'b1; cfg_cpu_main = 1'b1; cfg_tmr_main = 1'b1; cfg_wdt_long = 1'b1;
    @(negedge clk);
    clear_inputs();
    check("R10 tmr_clk_main set", tmr_clk_main, 1);
    check("R11 wdt_limit long", int'(wdt_limit), SUB * 18);
    cfg_we = 1'b1; cfg_cpu_main = 1'b1;
    @(negedge clk);
    clear_inputs();
    check("R10 tmr_clk_main clear", tmr_clk_main, 0);
    check("R11 wdt_limit short", int'(wdt_limit), SUB * 9 / 2);

    // R9: write of timer bit while asleep is dropped
    sleep_req = 1'b1;
    @(negedge clk);
    clear_inputs();
    check("R5 sleep before locked write", mode, 3);
    cfg_we = 1'b1; cfg_cpu_main = 1'b1; cfg_tmr_main = 1'b1; cfg_wdt_long = 1'b1;
    @(negedge clk);
    clear_inputs();
    check("R9 tmr_clk_main locked", tmr_clk_main, 0);
    check("R9 wdt_limit locked", int'(wdt_limit), SUB * 9 / 2);
    // R8: further sleep strobe during warm-up has no effect on its length
    wake_evt = 1'b1;
    @(negedge clk);
    clear_inputs();
    sleep_req = 1'b1;
    @(negedge clk);
    clear_inputs();
    check("R8 warm not slept", mode, 0);
    check("R8 warm halted", cpu_run, 0);
    for (int k = 0; k < WU - 1; k++) @(negedge clk);
    check("R8 warm end run", cpu_run, 1);
    check("R8 warm end clk", cpu_clk_main, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule